// File: doc/BRIEF.md
# Aligned-Store Block Copy Engine

This block copies a run of bytes from a source address to a destination address through one word-wide memory port that has per-byte write enables. A single start pulse supplies the source, the destination and the byte count. From then on the engine picks its own work pattern. If the destination sits inside a word, single bytes are moved until it reaches a word boundary. While at least one full word remains, whole-word stores are issued at aligned destination addresses. Any bytes that are left are then moved one at a time.

Only the destination is aligned. The source may keep any byte offset through the whole copy. During the word phase a holding register keeps the previous source word. Each outgoing word is then cut from the joined pair {new word, held word}, shifted by the source offset. Every read and write on the port uses a word-aligned address. Read data is taken one cycle after the read command.

Top module: `blkcpy_engine`

## Requirements
- R1: After reset, busy and done are low. No memory read or write is issued in any cycle where busy is low.
- R2: A start with a byte count of zero raises done in the very next cycle, with busy high for that one cycle, and makes no memory access.
- R3: When the destination's low three bits are nonzero, the engine first stores single bytes with exactly one write enable, at lane dst mod 8. It stops when the destination becomes aligned or the count runs out, so the number of such bytes is min(len, (8 - dst mod 8) mod 8). Example: 100 bytes from 345 to 123 give 5 single-byte stores, then word stores start at destination 128 with source 350 and 95 bytes left.
- R4: While the destination is aligned and at least 8 bytes remain, the engine issues full-word stores with all 8 write enables set, at consecutive aligned destination words.
- R5: In a full-word store, byte lane i carries source byte (s + i), where s is the current source address. This holds for every source offset 0 to 7.
- R6: Once fewer than 8 bytes remain, the rest are stored as single bytes (one enable, lane dst mod 8) until the count is zero. No full-word store is ever issued with fewer than 8 bytes left, so short copies use byte stores only.
- R7: Every address on the memory port has its low three bits at zero. Read and write are never issued in the same cycle.
- R8: Busy is high from the cycle after an accepted start through the cycle in which done is high. Done is high for exactly one cycle per copy.
- R9: A start pulse while busy is high is ignored. It causes no extra memory access and does not change the copy in progress.
- R10: After a copy, every destination byte equals its source byte, and every memory byte outside the destination range is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a copy when the engine is idle |
| src_addr | input | ADDR_W | Source byte address |
| dst_addr | input | ADDR_W | Destination byte address |
| byte_len | input | LEN_W | Number of bytes to copy |
| busy | output | 1 | High while a copy is in progress |
| done | output | 1 | One-cycle pulse when a copy ends |
| mem_rd | output | 1 | Word read command |
| mem_wr | output | 1 | Write command |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | 8*WORD_BYTES | Write data |
| mem_be | output | WORD_BYTES | Byte write enables |
| mem_rdata | input | 8*WORD_BYTES | Read data, valid the cycle after mem_rd |

## Verification
The embedded properties check these rules on every cycle: port addresses are aligned, reads and writes never overlap, the engine stays quiet while idle, done is a single pulse, and the strobe pattern is either one byte or a full word. They also check that a full-word store happens only with at least a word left and is always preceded by a read. The scoreboard alone shows the byte content of each merged word for each source offset, the exact split into head, body and tail stores, the handling of zero-length and ignored starts, and that memory outside the destination stays untouched.

// File: rtl/blkcpy_pkg.sv
package blkcpy_pkg;
   typedef enum logic [2:0] {
      CS_IDLE,
      CS_BRD,
      CS_BWR,
      CS_PRIME,
      CS_LOAD,
      CS_MERGE,
      CS_FETCH,
      CS_FIN
   } cpy_state_e;
endpackage

// File: rtl/blkcpy_seq.sv
module blkcpy_seq
   import blkcpy_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int WORD_BYTES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] src_addr,
   input  logic [ADDR_W-1:0] dst_addr,
   input  logic [LEN_W-1:0]  byte_len,
   output cpy_state_e        state_q,
   output logic [ADDR_W-1:0] src_q,
   output logic [ADDR_W-1:0] dst_q,
   output logic [LEN_W-1:0]  len_q
);
   localparam int OFF_W = $clog2(WORD_BYTES);
   localparam logic [LEN_W-1:0]  WB_L = LEN_W'(WORD_BYTES);
   localparam logic [ADDR_W-1:0] WB_A = ADDR_W'(WORD_BYTES);

   logic [LEN_W-1:0]  len_byte;
   logic [LEN_W-1:0]  len_word;
   logic [ADDR_W-1:0] dst_byte;

   always_comb begin
      len_byte = len_q - LEN_W'(1);
      len_word = len_q - WB_L;
      dst_byte = dst_q + ADDR_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= CS_IDLE;
         src_q   <= '0;
         dst_q   <= '0;
         len_q   <= '0;
      end else begin
         case (state_q)
            CS_IDLE: if (start) begin
               src_q <= src_addr;
               dst_q <= dst_addr;
               len_q <= byte_len;
               if (byte_len == '0)
                  state_q <= CS_FIN;
               else if (dst_addr[OFF_W-1:0] == '0 && byte_len >= WB_L)
                  state_q <= CS_PRIME;
               else
                  state_q <= CS_BRD;
            end
            CS_BRD:  state_q <= CS_BWR;
            CS_BWR: begin
               src_q <= src_q + ADDR_W'(1);
               dst_q <= dst_byte;
               len_q <= len_byte;
               if (len_byte == '0)
                  state_q <= CS_FIN;
               else if (dst_byte[OFF_W-1:0] == '0 && len_byte >= WB_L)
                  state_q <= CS_PRIME;
               else
                  state_q <= CS_BRD;
            end
            CS_PRIME: state_q <= CS_LOAD;
            CS_LOAD:  state_q <= CS_MERGE;
            CS_MERGE: begin
               src_q <= src_q + WB_A;
               dst_q <= dst_q + WB_A;
               len_q <= len_word;
               if (len_word >= WB_L)
                  state_q <= CS_FETCH;
               else if (len_word == '0)
                  state_q <= CS_FIN;
               else
                  state_q <= CS_BRD;
            end
            CS_FETCH: state_q <= CS_MERGE;
            CS_FIN:   state_q <= CS_IDLE;
            default:  state_q <= CS_IDLE;
         endcase
      end
   end

   // R3
   head_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CS_PRIME) |-> (dst_q[OFF_W-1:0] == '0 && len_q >= WB_L));

   // R9
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CS_BRD && start) |=> (state_q == CS_BWR));
endmodule

// File: rtl/blkcpy_merge.sv
module blkcpy_merge #(
   parameter int WORD_BYTES = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cap,
   input  logic [$clog2(WORD_BYTES)-1:0] shift,
   input  logic [8*WORD_BYTES-1:0]       rdata,
   output logic [8*WORD_BYTES-1:0]       merged
);
   localparam int DW    = 8 * WORD_BYTES;
   localparam int OFF_W = $clog2(WORD_BYTES);

   logic [DW-1:0]   hold_q;
   logic [2*DW-1:0] joined;

   always_ff @(posedge clk) begin
      if (!rst_n)
         hold_q <= '0;
      else if (cap)
         hold_q <= rdata;
   end

   always_comb begin
      joined = {rdata, hold_q} >> {shift, 3'b000};
      merged = joined[DW-1:0];
   end

   // R5
   hold_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> (hold_q == $past(rdata)));

   if (OFF_W < 1) begin : g_bad_width
      $error("blkcpy_merge needs at least two byte lanes");
   end
endmodule

// File: rtl/blkcpy_lane.sv
module blkcpy_lane #(
   parameter int WORD_BYTES = 8
) (
   input  logic [$clog2(WORD_BYTES)-1:0] src_off,
   input  logic [$clog2(WORD_BYTES)-1:0] dst_off,
   input  logic [8*WORD_BYTES-1:0]       rdata,
   output logic [WORD_BYTES-1:0]         byte_be,
   output logic [8*WORD_BYTES-1:0]       byte_wdata
);
   localparam int DW    = 8 * WORD_BYTES;
   localparam int OFF_W = $clog2(WORD_BYTES);

   logic [DW-1:0] shifted;
   logic [7:0]    picked;

   always_comb begin
      shifted = rdata >> {src_off, 3'b000};
      picked  = shifted[7:0];
   end

   for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
      assign byte_be[g]          = (dst_off == OFF_W'(g));
      assign byte_wdata[8*g +: 8] = picked;
   end
endmodule

// File: rtl/blkcpy_engine.sv
module blkcpy_engine
   import blkcpy_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int WORD_BYTES = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [ADDR_W-1:0]       src_addr,
   input  logic [ADDR_W-1:0]       dst_addr,
   input  logic [LEN_W-1:0]        byte_len,
   output logic                    busy,
   output logic                    done,
   output logic                    mem_rd,
   output logic                    mem_wr,
   output logic [ADDR_W-1:0]       mem_addr,
   output logic [8*WORD_BYTES-1:0] mem_wdata,
   output logic [WORD_BYTES-1:0]   mem_be,
   input  logic [8*WORD_BYTES-1:0] mem_rdata
);
   localparam int DW    = 8 * WORD_BYTES;
   localparam int OFF_W = $clog2(WORD_BYTES);
   localparam logic [LEN_W-1:0]  WB_L = LEN_W'(WORD_BYTES);
   localparam logic [ADDR_W-1:0] WB_A = ADDR_W'(WORD_BYTES);

   if (WORD_BYTES < 2 || (1 << OFF_W) != WORD_BYTES) begin : g_bad_word
      $error("WORD_BYTES must be a power of two, at least 2");
   end
   if (LEN_W < 1 || ADDR_W <= OFF_W) begin : g_bad_addr
      $error("address and length widths too small");
   end

   cpy_state_e        state_q;
   logic [ADDR_W-1:0] src_q, dst_q;
   logic [LEN_W-1:0]  len_q;
   logic [ADDR_W-1:0] src_word, dst_word;
   logic [DW-1:0]     merged, byte_wdata;
   logic [WORD_BYTES-1:0] byte_be;
   logic              rd_next;

   blkcpy_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .WORD_BYTES(WORD_BYTES)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .src_addr(src_addr), .dst_addr(dst_addr), .byte_len(byte_len),
      .state_q(state_q), .src_q(src_q), .dst_q(dst_q), .len_q(len_q)
   );

   blkcpy_merge #(.WORD_BYTES(WORD_BYTES)) u_merge (
      .clk(clk), .rst_n(rst_n),
      .cap(state_q == CS_LOAD || state_q == CS_MERGE),
      .shift(src_q[OFF_W-1:0]), .rdata(mem_rdata), .merged(merged)
   );

   blkcpy_lane #(.WORD_BYTES(WORD_BYTES)) u_lane (
      .src_off(src_q[OFF_W-1:0]), .dst_off(dst_q[OFF_W-1:0]),
      .rdata(mem_rdata), .byte_be(byte_be), .byte_wdata(byte_wdata)
   );

   always_comb begin
      src_word  = {src_q[ADDR_W-1:OFF_W], OFF_W'(0)};
      dst_word  = {dst_q[ADDR_W-1:OFF_W], OFF_W'(0)};
      rd_next   = (state_q == CS_LOAD) || (state_q == CS_FETCH);
      mem_rd    = (state_q == CS_BRD) || (state_q == CS_PRIME) || rd_next;
      mem_wr    = (state_q == CS_BWR) || (state_q == CS_MERGE);
      busy      = (state_q != CS_IDLE);
      done      = (state_q == CS_FIN);
      if (mem_wr)
         mem_addr = dst_word;
      else if (rd_next)
         mem_addr = src_word + WB_A;
      else
         mem_addr = src_word;
      mem_be    = (state_q == CS_MERGE) ? '1 : ((state_q == CS_BWR) ? byte_be : '0);
      mem_wdata = (state_q == CS_MERGE) ? merged : ((state_q == CS_BWR) ? byte_wdata : '0);
   end

   // R7
   addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> (mem_addr[OFF_W-1:0] == '0));

   // R7
   port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_rd && !mem_wr));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   word_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && (&mem_be)) |-> (len_q >= WB_L));

   // R3
   strobe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> ((&mem_be) || $onehot(mem_be)));

   // R5
   read_before_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> $past(mem_rd));
endmodule

// File: tb/blkcpy_engine_test.sv
module blkcpy_engine_test;
   localparam int AW = 32;
   localparam int LW = 16;
   localparam int WB = 8;
   localparam int DW = 64;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] src_in = '0;
   logic [AW-1:0] dst_in = '0;
   logic [LW-1:0] len_in = '0;
   logic          busy, done, mem_rd, mem_wr;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [WB-1:0] mem_be;
   logic [DW-1:0] mem_rdata = '0;

   logic [7:0] mem    [0:1023];
   logic [7:0] shadow [0:1023];

   logic [AW-1:0] q_addr [$];
   logic [WB-1:0] q_be   [$];
   logic [DW-1:0] q_data [$];
   string         q_tag  [$];

   int checks = 0;
   int errors = 0;
   int mem_ops = 0;
   int cyc = 0;

   blkcpy_engine #(.ADDR_W(AW), .LEN_W(LW), .WORD_BYTES(WB)) uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .src_addr(src_in), .dst_addr(dst_in), .byte_len(len_in),
      .busy(busy), .done(done), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
      .mem_rdata(mem_rdata)
   );

   function automatic logic [7:0] pat(int a);
      return 8'((a * 37 + 11) ^ (a >> 3));
   endfunction

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // memory model: read data one cycle after the command
   always @(posedge clk) begin
      int idx;
      idx = int'(mem_addr[9:0]);
      if (mem_rd)
         for (int b = 0; b < WB; b++) mem_rdata[8*b +: 8] <= mem[idx + b];
      if (mem_wr)
         for (int b = 0; b < WB; b++)
            if (mem_be[b]) mem[idx + b] <= mem_wdata[8*b +: 8];
   end

   // monitor: pops expected stores and compares
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_rd || mem_wr) begin
            mem_ops++;
            chk(mem_addr[2:0] == 3'd0, "R7", "port address alignment", mem_addr, {mem_addr[AW-1:3], 3'd0});
         end
         if (mem_wr) begin
            if (q_addr.size() == 0) begin
               chk(1'b0, "R9", "unexpected store", mem_addr, 0);
            end else begin
               logic [AW-1:0] ea;
               logic [WB-1:0] eb;
               logic [DW-1:0] ed, mask;
               string t;
               ea = q_addr.pop_front();
               eb = q_be.pop_front();
               ed = q_data.pop_front();
               t  = q_tag.pop_front();
               for (int b = 0; b < WB; b++) mask[8*b +: 8] = {8{eb[b]}};
               chk(mem_addr == ea, t, "store address", mem_addr, ea);
               chk(mem_be == eb, t, "store strobes", mem_be, eb);
               chk((mem_wdata & mask) == (ed & mask), t, "store data", mem_wdata & mask, ed & mask);
            end
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL R8 watchdog: actual %0d cycles expected below 150000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic push_byte(int s, int d, string t);
      logic [DW-1:0] w;
      w = '0;
      w[8*(d % 8) +: 8] = pat(s);
      q_addr.push_back(AW'(d - d % 8));
      q_be.push_back(WB'(1) << (d % 8));
      q_data.push_back(w);
      q_tag.push_back(t);
      shadow[d] = pat(s);
   endtask

   task automatic push_word(int s, int d);
      logic [DW-1:0] w;
      for (int b = 0; b < WB; b++) begin
         w[8*b +: 8] = pat(s + b);
         shadow[d + b] = pat(s + b);
      end
      q_addr.push_back(AW'(d));
      q_be.push_back('1);
      q_data.push_back(w);
      q_tag.push_back("R4/R5 body");
   endtask

   task automatic run_copy(int s0, int d0, int n0, bit inject);
      int s, d, n, cnt, ops0, nhead;
      bit busy_ok;
      s = s0; d = d0; n = n0; nhead = 0;
      while (n > 0 && d % 8 != 0) begin push_byte(s, d, "R3 head"); s++; d++; n--; nhead++; end
      while (n >= 8) begin push_word(s, d); s += 8; d += 8; n -= 8; end
      while (n > 0) begin push_byte(s, d, "R6 tail"); s++; d++; n--; end
      // R3: head byte count from the alignment formula
      chk(nhead == ((n0 < (8 - d0 % 8) % 8) ? n0 : (8 - d0 % 8) % 8), "R3", "head count", nhead,
          (n0 < (8 - d0 % 8) % 8) ? n0 : (8 - d0 % 8) % 8);
      ops0 = mem_ops;
      @(negedge clk);
      start = 1'b1; src_in = AW'(s0); dst_in = AW'(d0); len_in = LW'(n0);
      @(negedge clk);
      start = 1'b0;
      cnt = 0; busy_ok = 1'b1;
      while (!done && cnt < 5000) begin
         if (!busy) busy_ok = 1'b0;
         if (inject && cnt == 3) begin
            start = 1'b1; src_in = AW'(0); dst_in = AW'(900); len_in = LW'(8);
         end
         if (inject && cnt == 4) start = 1'b0;
         @(negedge clk);
         cnt++;
      end
      chk(done, "R8", "done reached", done, 1);
      chk(busy, "R8", "busy during done", busy, 1);
      chk(busy_ok, "R8", "busy held through copy", busy_ok, 1);
      if (n0 == 0) begin
         // R2: done in the cycle after start, no memory traffic
         chk(cnt == 0, "R2", "zero-length latency", cnt, 0);
         chk(mem_ops == ops0, "R2", "zero-length accesses", mem_ops - ops0, 0);
      end
      @(negedge clk);
      chk(!done && !busy, "R8", "done single pulse", {done, busy}, 0);
      chk(q_addr.size() == 0, "R10", "stores outstanding", q_addr.size(), 0);
      if (inject) begin
         ops0 = mem_ops;
         repeat (5) @(negedge clk);
         chk(!busy && mem_ops == ops0, "R9", "start while busy ignored", mem_ops - ops0, 0);
      end
      begin
         int bad;
         bad = 0;
         for (int i = 0; i < 1024; i++) if (mem[i] !== shadow[i]) bad++;
         chk(bad == 0, "R10", "memory image mismatches", bad, 0);
      end
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) begin
         mem[i] = pat(i);
         shadow[i] = pat(i);
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(!busy && !done && !mem_rd && !mem_wr, "R1", "reset outputs",
          {busy, done, mem_rd, mem_wr}, 0);
      run_copy(40, 600, 0, 1'b0);       // R2 zero length
      run_copy(345, 635, 100, 1'b0);    // R3 head of 5, misaligned source body
      run_copy(64, 512, 32, 1'b0);      // R4 body only, offset 0
      for (int off = 0; off < 8; off++)
         run_copy(100 + off, 650, 27, 1'b0);   // R5 every source offset
      run_copy(200, 701, 2, 1'b0);      // R3 head cut short by length
      run_copy(210, 704, 5, 1'b0);      // R6 tail only
      run_copy(220, 765, 3, 1'b0);      // R3 head ends at alignment
      run_copy(7, 520, 9, 1'b0);        // R6 one word then one tail byte
      run_copy(300, 560, 16, 1'b1);     // R9 start while busy
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule